// File: doc/BRIEF.md
# Dual-Address Display Channel I2C Slave

This block is the slave side of a video sink's display data channel. It watches the open-drain SCL and SDA wires and answers two 7-bit device addresses. The identification address serves a read-only byte store that sits outside the block, reached through a one-cycle-latency RAM read port. The status/control address is forwarded to a byte-wide register port of the receiver core, with one-cycle write and read strobes. The block only pulls SDA low, and never drives it high. It never stretches SCL.

One byte offset is shared by both targets. In a write transfer, the first data byte after the device address loads the offset. Each later byte goes to the current offset, and the offset then advances. A read transfer returns bytes from the current offset onward and advances the offset after each byte. It ends when the master answers a byte with NACK. Both lines pass through a two-stage synchronizer and a persistence filter before START, STOP and clock edges are decoded. The slave stays silent until the hot-plug-detect input has shown a rising edge, and goes silent again when that input falls.

Top module: `ddc_i2c_slave`

## Requirements
- R1: The address byte 8'hA0 (write) or 8'hA1 (read) is ACKed, and reads at that address return the byte-store data for the current offset (rom_rdata one clock after rom_addr).
- R2: The address byte 8'hA8 (write) or 8'hA9 (read) is ACKed, and the data moves through reg_addr/reg_wdata/reg_we and reg_addr/reg_rdata/reg_rd.
- R3: Any other address byte is NACKed (SDA left high in the ninth bit), and sda_oe stays low for the rest of that transfer until the next START.
- R4: No address is ACKed before a rising edge has been seen on hpd_i, or while hpd_i is low.
- R5: In a write transfer, the first data byte loads the offset. Each later byte to the register address gives exactly one single-cycle reg_we at the current offset, and the offset then increments. Every data byte is ACKed.
- R6: A read returns bytes MSB first, starting at the current offset. The offset increments after each byte, and the read stops after a master NACK. Each register byte read gives exactly one single-cycle reg_rd.
- R7: A repeated START (START with no STOP before it) restarts the address phase, and the offset is kept across it and across STOP.
- R8: An SDA or SCL pulse shorter than FILT_LEN system clocks is ignored. In particular, a short low glitch on SDA while SCL is high creates no START or STOP.
- R9: After reset, sda_oe, reg_we and reg_rd are low.
- R10: Data bytes written to the identification address are ACKed and advance the offset, but produce no reg_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL wire |
| sda_i | input | 1 | Sampled SDA wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| hpd_i | input | 1 | Hot-plug-detect level |
| rom_addr | output | OFS_W | Byte-store read address (current offset) |
| rom_rdata | input | 8 | Byte-store data, one clock after rom_addr |
| reg_addr | output | OFS_W | Register port address (current offset) |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_rd | output | 1 | Single-cycle read strobe; reg_rdata sampled in the same cycle |
| reg_rdata | input | 8 | Register read data, combinational from reg_addr |

## Verification
Assertions check on every cycle the properties that follow from state alone. Both strobes last one cycle. Writes never target the identification store. An ACK phase is entered only while the hot-plug flag is armed. SDA is released whenever the link is idle. A filtered line changes only after its synchronized input has disagreed with it. Whether the right bytes arrive at the right offsets can only be shown by the bench's bus scenarios. So can the address decode table, offset carry-over across repeated START and STOP, and the SDA glitch that must not break a transfer.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK
    } link_state_t;

    typedef enum logic {
        TGT_ID = 1'b0,
        TGT_SC = 1'b1
    } target_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    function automatic logic dev_hit(input logic [7:0] addr_byte, input logic [6:0] dev);
        return addr_byte[7:1] == dev;
    endfunction

endpackage

// File: rtl/ddc_line_filter.sv
module ddc_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            clean   <= 1'b1;
            run_cnt <= '0;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == clean) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(FILT_LEN - 1)) begin
                clean   <= sync_q[1];
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // R8: the filtered line only moves toward a differing synchronized input
    a_r8_filter_follows: assert property (@(posedge clk) disable iff (rst)
        !$stable(clean) |-> ($past(sync_q[1]) != $past(clean)));

endmodule

// File: rtl/ddc_bus_events.sv
module ddc_bus_events
    import ddc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_c,
    input  logic    sda_c,
    input  logic    hpd_i,
    output bus_ev_t ev,
    output logic    armed
);
    logic scl_q, sda_q;
    logic [1:0] hpd_s;
    logic hpd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            hpd_s <= 2'b00;
            hpd_q <= 1'b0;
            armed <= 1'b0;
        end else begin
            scl_q <= scl_c;
            sda_q <= sda_c;
            hpd_s <= {hpd_s[0], hpd_i};
            hpd_q <= hpd_s[1];
            if (!hpd_s[1])
                armed <= 1'b0;
            else if (!hpd_q)
                armed <= 1'b1;
        end
    end

    always_comb begin
        ev.start    = scl_c & scl_q & sda_q & ~sda_c;
        ev.stop     = scl_c & scl_q & ~sda_q & sda_c;
        ev.scl_rise = scl_c & ~scl_q;
        ev.scl_fall = ~scl_c & scl_q;
        ev.sda      = sda_c;
    end

endmodule

// File: rtl/ddc_link_fsm.sv
module ddc_link_fsm
    import ddc_pkg::*;
#(
    parameter logic [6:0] DEV_ID = 7'h50,
    parameter logic [6:0] DEV_SC = 7'h54,
    parameter int         OFS_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  logic             armed,
    input  logic [7:0]       rd_byte,
    output logic             sda_oe,
    output logic [OFS_W-1:0] offset,
    output target_t          tgt,
    output logic             rd_take,
    output logic             wr_strobe,
    output logic [7:0]       wr_data
);
    link_state_t st;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg;
    logic        dir_rd;
    logic        first_data;
    logic        got_ack;
    logic        hit_id, hit_sc;

    assign hit_id = dev_hit(shreg, DEV_ID);
    assign hit_sc = dev_hit(shreg, DEV_SC);

    always_comb begin
        rd_take = 1'b0;
        if (!ev.start && !ev.stop && ev.scl_fall) begin
            if (st == ST_ADDR_ACK && dir_rd)
                rd_take = 1'b1;
            else if (st == ST_RD_ACK && got_ack)
                rd_take = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            dir_rd     <= 1'b0;
            first_data <= 1'b0;
            got_ack    <= 1'b0;
            sda_oe     <= 1'b0;
            offset     <= '0;
            tgt        <= TGT_ID;
            wr_strobe  <= 1'b0;
            wr_data    <= '0;
        end else begin
            wr_strobe <= 1'b0;
            if (ev.start) begin
                st     <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR: begin
                        if (ev.scl_rise) begin
                            shreg  <= {shreg[6:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.scl_fall && bitcnt == 4'd8) begin
                            if (armed && (hit_id || hit_sc)) begin
                                tgt    <= hit_sc ? TGT_SC : TGT_ID;
                                dir_rd <= shreg[0];
                                sda_oe <= 1'b1;
                                st     <= ST_ADDR_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (rd_take) begin
                            shreg  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            bitcnt <= 4'd1;
                            st     <= ST_RD_DATA;
                        end else if (ev.scl_fall) begin
                            sda_oe     <= 1'b0;
                            bitcnt     <= '0;
                            first_data <= 1'b1;
                            st         <= ST_WR_DATA;
                        end
                    end
                    ST_WR_DATA: begin
                        if (ev.scl_rise) begin
                            shreg  <= {shreg[6:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.scl_fall && bitcnt == 4'd8) begin
                            sda_oe <= 1'b1;
                            st     <= ST_WR_ACK;
                            if (first_data) begin
                                offset <= shreg[OFS_W-1:0];
                            end else if (tgt == TGT_SC) begin
                                wr_strobe <= 1'b1;
                                wr_data   <= shreg;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe     <= 1'b0;
                            bitcnt     <= '0;
                            st         <= ST_WR_DATA;
                            first_data <= 1'b0;
                            if (!first_data)
                                offset <= offset + 1'b1;
                        end
                    end
                    ST_RD_DATA: begin
                        if (ev.scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                st     <= ST_RD_ACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_rise) begin
                            got_ack <= ~ev.sda;
                            offset  <= offset + 1'b1;
                        end else if (rd_take) begin
                            shreg  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            bitcnt <= 4'd1;
                            st     <= ST_RD_DATA;
                        end else if (ev.scl_fall) begin
                            st <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: an idle link never holds SDA
    a_r3_idle_released: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe);

    // R4: an address ACK phase starts only while the hot-plug flag is armed
    a_r4_ack_needs_hpd: assert property (@(posedge clk) disable iff (rst)
        $rose(st == ST_ADDR_ACK) |-> $past(armed));

    // R10: writes are never issued toward the identification store
    a_r10_no_id_write: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (tgt == TGT_SC));

endmodule

// File: rtl/ddc_i2c_slave.sv
module ddc_i2c_slave
    import ddc_pkg::*;
#(
    parameter logic [6:0] DEV_ID   = 7'h50,
    parameter logic [6:0] DEV_SC   = 7'h54,
    parameter int         OFS_W    = 8,
    parameter int         FILT_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             hpd_i,
    output logic [OFS_W-1:0] rom_addr,
    input  logic [7:0]       rom_rdata,
    output logic [OFS_W-1:0] reg_addr,
    output logic [7:0]       reg_wdata,
    output logic             reg_we,
    output logic             reg_rd,
    input  logic [7:0]       reg_rdata
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, clean_lines;
    bus_ev_t           ev;
    logic              armed;
    logic [7:0]        rd_byte;
    logic [OFS_W-1:0]  offset;
    target_t           tgt;
    logic              rd_take;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        ddc_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_lines[g]),
            .clean(clean_lines[g])
        );
    end

    ddc_bus_events u_events (
        .clk  (clk),
        .rst  (rst),
        .scl_c(clean_lines[0]),
        .sda_c(clean_lines[1]),
        .hpd_i(hpd_i),
        .ev   (ev),
        .armed(armed)
    );

    assign rd_byte = (tgt == TGT_SC) ? reg_rdata : rom_rdata;

    ddc_link_fsm #(
        .DEV_ID(DEV_ID),
        .DEV_SC(DEV_SC),
        .OFS_W (OFS_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .armed    (armed),
        .rd_byte  (rd_byte),
        .sda_oe   (sda_oe),
        .offset   (offset),
        .tgt      (tgt),
        .rd_take  (rd_take),
        .wr_strobe(reg_we),
        .wr_data  (reg_wdata)
    );

    assign rom_addr = offset;
    assign reg_addr = offset;
    assign reg_rd   = rd_take && (tgt == TGT_SC);

    // R5: register write strobe lasts one cycle
    a_r5_we_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R6: register read strobe lasts one cycle
    a_r6_rd_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> !reg_rd);

endmodule

// File: tb/ddc_i2c_slave_test.sv
`timescale 1ns/1ps
module ddc_i2c_slave_test;
    localparam int OFS_W = 8;
    localparam int Q     = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic hpd = 1'b0;
    logic sda_oe, sda_bus;
    logic [OFS_W-1:0] rom_addr, reg_addr;
    logic [7:0] rom_rdata, reg_wdata, reg_rdata;
    logic reg_we, reg_rd;

    logic [7:0] regs [256];
    int checks = 0;
    int errors = 0;
    int we_cnt = 0;
    int rd_cnt = 0;
    int oe_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    ddc_i2c_slave uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .hpd_i(hpd), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] rom_fn(input logic [7:0] a);
        return 8'(a * 3 + 7);
    endfunction

    always @(posedge clk) rom_rdata <= rom_fn(rom_addr);
    assign reg_rdata = regs[reg_addr];
    always @(posedge clk) begin
        if (reg_we) begin
            regs[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (reg_rd) rd_cnt <= rd_cnt + 1;
        if (sda_oe) oe_cnt <= oe_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic wr_bit(input logic b, input bit glitch);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(Q);
        if (glitch) begin
            sda_m = 1'b0; wq(2);
            sda_m = 1'b1;
        end
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic rd_bit(output logic v);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        v = sda_bus; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic wr_byte(input logic [7:0] d, input int glitch_bit, output logic ackn);
        for (int i = 7; i >= 0; i--) wr_bit(d[i], (i == glitch_bit) && d[i]);
        rd_bit(ackn);
    endtask

    task automatic rd_byte(input logic last, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            logic v;
            rd_bit(v);
            d[i] = v;
        end
        wr_bit(last, 1'b0);
    endtask

    // {address byte, expected ACK}; A0/A1 and A8/A9 are ACKed, all others NACKed
    localparam logic [8:0] VEC [9] = '{
        {8'hA0, 1'b1}, {8'hA1, 1'b1}, {8'hA8, 1'b1}, {8'hA9, 1'b1},
        {8'hA2, 1'b0}, {8'h50, 1'b0}, {8'hAA, 1'b0}, {8'hB0, 1'b0}, {8'h00, 1'b0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic an;
        logic [7:0] d;
        int we0, rd0;
        for (int i = 0; i < 256; i++) regs[i] = 8'(i ^ 8'hC3);
        regs[8'h23] = 8'h5C;
        wq(10);
        rst = 1'b0;
        wq(3);
        // R9 reset state
        chk(!sda_oe && !reg_we && !reg_rd, "R9", {sda_oe, reg_we, reg_rd}, 0);

        // R4: silent before a hot-plug rising edge
        i2c_start(); wr_byte(8'hA0, -1, an); i2c_stop();
        chk(an == 1'b1, "R4 before hpd", an, 1);

        hpd = 1'b1; wq(10);

        // R1/R2/R3 address decode table
        foreach (VEC[k]) begin
            i2c_start();
            wr_byte(VEC[k][8:1], -1, an);
            chk(an == ~VEC[k][0], VEC[k][0] ? "R1/R2 addr ack" : "R3 addr nack", an, ~VEC[k][0]);
            if (!an && VEC[k][1]) rd_byte(1'b1, d);
            i2c_stop();
        end

        // R1 R7: set offset, repeated START, read three bytes
        i2c_start(); wr_byte(8'hA0, -1, an); wr_byte(8'h10, -1, an);
        i2c_start(); wr_byte(8'hA1, -1, an);
        for (int j = 0; j < 3; j++) begin
            rd_byte(j == 2, d);
            chk(d == rom_fn(8'(8'h10 + j)), "R1 R7 id read", d, rom_fn(8'(8'h10 + j)));
        end
        i2c_stop();

        // R5 R8: register write of three bytes, with an SDA glitch while SCL high
        we0 = we_cnt;
        i2c_start(); wr_byte(8'hA8, -1, an); wr_byte(8'h20, -1, an);
        wr_byte(8'h11, 4, an); chk(an == 1'b0, "R5 R8 data ack", an, 0);
        wr_byte(8'h22, -1, an);
        wr_byte(8'h33, 5, an);
        i2c_stop();
        chk(regs[8'h20] == 8'h11, "R5 R8 write0", regs[8'h20], 8'h11);
        chk(regs[8'h21] == 8'h22, "R5 write1", regs[8'h21], 8'h22);
        chk(regs[8'h22] == 8'h33, "R5 R8 write2", regs[8'h22], 8'h33);
        chk(we_cnt - we0 == 3, "R5 strobe count", we_cnt - we0, 3);

        // R6 R7: register read back, one reg_rd per byte
        rd0 = rd_cnt;
        i2c_start(); wr_byte(8'hA8, -1, an); wr_byte(8'h21, -1, an);
        i2c_start(); wr_byte(8'hA9, -1, an);
        rd_byte(1'b0, d); chk(d == 8'h22, "R6 R7 reg read0", d, 8'h22);
        rd_byte(1'b1, d); chk(d == 8'h33, "R6 reg read1", d, 8'h33);
        i2c_stop();
        chk(rd_cnt - rd0 == 2, "R6 rd strobes", rd_cnt - rd0, 2);

        // R7 R6: current-offset read continues after STOP
        i2c_start(); wr_byte(8'hA9, -1, an);
        rd_byte(1'b1, d); i2c_stop();
        chk(d == 8'h5C, "R7 offset kept", d, 8'h5C);

        // R10: data written to the id address is ACKed, no reg_we, offset moves
        we0 = we_cnt;
        i2c_start(); wr_byte(8'hA0, -1, an); wr_byte(8'h40, -1, an);
        wr_byte(8'h99, -1, an); chk(an == 1'b0, "R10 id data ack", an, 0);
        i2c_start(); wr_byte(8'hA1, -1, an); rd_byte(1'b1, d); i2c_stop();
        chk(we_cnt == we0, "R10 no reg_we", we_cnt - we0, 0);
        chk(d == rom_fn(8'h41), "R10 offset advanced", d, rom_fn(8'h41));

        // R3: after a NACKed address, SDA stays released for further bytes
        oe_cnt = 0; we0 = we_cnt;
        i2c_start(); wr_byte(8'hA2, -1, an); wr_byte(8'h00, -1, an);
        chk(an == 1'b1, "R3 following byte nack", an, 1);
        wr_byte(8'h00, -1, an);
        i2c_stop();
        chk(oe_cnt == 0 && we_cnt == we0, "R3 sda released", oe_cnt, 0);

        // R4: hot-plug low silences the slave
        hpd = 1'b0; wq(10);
        i2c_start(); wr_byte(8'hA8, -1, an); i2c_stop();
        chk(an == 1'b1, "R4 hpd low", an, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule